// File: doc/BRIEF.md
# Two-Level Priority Bus Arbiter

This block decides which of three internal bus masters owns a shared bus, and also settles contention for the external bus. The internal masters are a DMA controller, a data-transfer controller and the CPU. Each master has its own request bit and acknowledge bit. Arbitration happens only at a bus-cycle boundary, which is marked by a one-cycle strobe. At that boundary, if the current holder still requests the bus, it keeps it. Otherwise the highest-priority requester wins. When nobody requests, the CPU is recorded as the default owner.

A second layer runs every clock and handles three claims on the external bus: a DRAM refresh request, a request from an outside device to take over the external bus (a release), and an external access by the internal master that currently holds the bus. Refresh beats release. Release beats the internal external access. Refresh and the internal external access may be granted in the same cycle.

Once a release is granted, it is held for as long as it is requested. The release function is switched off whenever the device is in sleep mode and the module-stop word has one of two specific values. Internal-bus arbitration continues unchanged while the external bus is released.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset, `bus_ack`, `rel_ack`, `rfsh_gnt` and `xacc_gnt` are all 0, and `bus_owner` is 3'b001 (the CPU).
- R2: Request and acknowledge bit 2 belongs to the DMA controller, bit 1 to the data-transfer controller and bit 0 to the CPU. A new grant goes to the highest set bit, and `bus_ack` never has more than one bit set.
- R3: `bus_ack` changes only on a clock edge where `cyc_end` is 1. Between strobes it stays unchanged, whatever happens to the requests.
- R4: At a `cyc_end` edge, a holder whose request is still high keeps its acknowledge, even if higher-priority masters are requesting. If the holder has dropped its request, the bus goes to the highest current requester.
- R5: `bus_owner` is one-hot at all times. At each `cyc_end` edge that re-arbitrates, it takes the new grant, or 3'b001 when no master requests. While any acknowledge is set, it equals `bus_ack`.
- R6: `rfsh_gnt` is 1 in the cycle after any cycle in which `rfsh_req` is 1 and `rel_ack` is 0.
- R7: `rel_ack` rises in the cycle after `rel_req` is 1, release is enabled and `rfsh_req` is 0. It then stays 1 while `rel_req` remains 1 and release stays enabled. `rel_ack` is never 1 together with `rfsh_gnt` or `xacc_gnt`.
- R8: `xacc_gnt` is 1 in the cycle after `xacc_req` is 1, some bit of `bus_ack` is 1, and release is not granted for that next cycle. It may be 1 together with `rfsh_gnt`.
- R9: Release is disabled, and `rel_ack` is 0 in the following cycle, whenever `sleep_mode` is 1 and `stop_word` is 16'hFFFF or 16'hEFFF. Any other `stop_word` value, or `sleep_mode` at 0, leaves release enabled.
- R10: The external-bus requests and grants have no effect on `bus_ack` or `bus_owner`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 3 | Internal-master requests (2 DMA, 1 data-transfer, 0 CPU) |
| bus_ack | output | 3 | Internal-master acknowledges, at most one set |
| bus_owner | output | 3 | One-hot current or default owner of the internal bus |
| cyc_end | input | 1 | Bus-cycle boundary strobe; the only point where ownership may move |
| rel_req | input | 1 | External request to release the external bus |
| rel_ack | output | 1 | External bus released |
| rfsh_req | input | 1 | DRAM refresh request |
| rfsh_gnt | output | 1 | Refresh granted |
| xacc_req | input | 1 | External access by the current internal holder |
| xacc_gnt | output | 1 | Internal external access granted |
| sleep_mode | input | 1 | Device is in sleep mode |
| stop_word | input | 16 | Module-stop control word |

## Verification
A wrong holder or priority state shows on `bus_ack` one edge after the `cyc_end` strobe that re-arbitrates. A state that moves ownership early shows as a change in `bus_ack` on an edge without the strobe. A faulty external-layer state shows one edge after the request pattern, as a wrong grant or as a release overlapping a refresh or an external access. A wrong halt decode shows up when `rel_ack` stays high, or fails to rise, on the cycle after a sweep of `stop_word` values with `sleep_mode` at 0 and at 1.

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter int          NM     = 3,
  parameter logic [15:0] HALT_A = 16'hFFFF,
  parameter logic [15:0] HALT_B = 16'hEFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] bus_req,
  output logic [NM-1:0] bus_ack,
  output logic [NM-1:0] bus_owner,
  input  logic          cyc_end,
  input  logic          rel_req,
  output logic          rel_ack,
  input  logic          rfsh_req,
  output logic          rfsh_gnt,
  input  logic          xacc_req,
  output logic          xacc_gnt,
  input  logic          sleep_mode,
  input  logic [15:0]   stop_word
);
  localparam logic [NM-1:0] DEF_OWNER = NM'(1);

  logic [NM-1:0] pick;
  always_comb begin
    pick = '0;
    for (int i = 0; i < NM; i++)
      if (bus_req[i]) pick = NM'(1) << i;
  end

  wire holding  = |(bus_ack & bus_req);
  wire rel_halt = sleep_mode && (stop_word == HALT_A || stop_word == HALT_B);
  wire rel_nx   = rel_req && !rel_halt && (rel_ack || !rfsh_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= '0;
      bus_owner <= DEF_OWNER;
      rel_ack   <= 1'b0;
      rfsh_gnt  <= 1'b0;
      xacc_gnt  <= 1'b0;
    end else begin
      if (cyc_end && !holding) begin
        bus_ack   <= pick;
        bus_owner <= (|pick) ? pick : DEF_OWNER;
      end
      rel_ack  <= rel_nx;
      rfsh_gnt <= rfsh_req && !rel_nx;
      xacc_gnt <= xacc_req && (|bus_ack) && !rel_nx;
    end
  end
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk #(
  parameter int          NM     = 3,
  parameter logic [15:0] HALT_A = 16'hFFFF,
  parameter logic [15:0] HALT_B = 16'hEFFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] bus_req,
  input logic [NM-1:0] bus_ack,
  input logic [NM-1:0] bus_owner,
  input logic          cyc_end,
  input logic          rel_req,
  input logic          rel_ack,
  input logic          rfsh_req,
  input logic          rfsh_gnt,
  input logic          xacc_req,
  input logic          xacc_gnt,
  input logic          sleep_mode,
  input logic [15:0]   stop_word
);
  p_top_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && !(|(bus_ack & bus_req)) && bus_req[NM-1] |=> bus_ack[NM-1]);
  p_ack_onehot0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_ack));
  p_no_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(bus_ack));
  p_keep_holder_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && (|(bus_ack & bus_req)) |=> $stable(bus_ack));
  p_owner_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(bus_owner));
  p_owner_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_ack) |-> bus_ack == bus_owner);
  p_refresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req && !rel_ack |=> rfsh_gnt);
  p_rel_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ack |-> !rfsh_gnt && !xacc_gnt);
  p_rel_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_req |=> !rel_ack);
  p_xacc_needs_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|bus_ack) || !xacc_req |=> !xacc_gnt);
  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_mode && (stop_word == HALT_A || stop_word == HALT_B) |=> !rel_ack);
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(.NM(NM), .HALT_A(HALT_A), .HALT_B(HALT_B)) chk_i (.*);

// File: tb/prio_bus_arbiter_tb.sv
`timescale 1ns/1ps
module prio_bus_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_req = '0;
  logic [2:0] bus_ack, bus_owner;
  logic cyc_end = 1'b0, rel_req = 1'b0, rfsh_req = 1'b0, xacc_req = 1'b0, sleep_mode = 1'b0;
  logic rel_ack, rfsh_gnt, xacc_gnt;
  logic [15:0] stop_word = 16'h0000;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_bus_arbiter dut_i (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] top_bit(input logic [2:0] r);
    return r[2] ? 3'b100 : r[1] ? 3'b010 : r[0] ? 3'b001 : 3'b000;
  endfunction

  task automatic free_bus();
    bus_req = '0; cyc_end = 1'b1; tick(); cyc_end = 1'b0;
  endtask

  initial begin
    logic [2:0] e, rest;
    logic er, ef, ex;
    logic [15:0] vals [6];
    vals = '{16'hFFFF, 16'hEFFF, 16'hFFFE, 16'hEFFE, 16'h7FFF, 16'h0000};
    repeat (3) tick();
    check("R1 ack", 32'(bus_ack), 0);
    check("R1 owner", 32'(bus_owner), 1);
    check("R1 ext", {rel_ack, rfsh_gnt, xacc_gnt}, 0);
    rst_n = 1'b1; tick();

    for (int p = 0; p < 8; p++) begin
      free_bus();
      check("R5 idle owner", 32'(bus_owner), 1);
      bus_req = 3'(p); cyc_end = 1'b1; tick(); cyc_end = 1'b0;
      e = top_bit(3'(p));
      check("R2 grant", 32'(bus_ack), 32'(e));
      check("R5 owner", 32'(bus_owner), (p == 0) ? 1 : 32'(e));
      bus_req = 3'b111; tick(); tick();
      check("R3 no strobe", 32'(bus_ack), 32'(e));
      cyc_end = 1'b1; tick(); cyc_end = 1'b0;
      check("R4 holder kept", 32'(bus_ack), (p == 0) ? 32'h4 : 32'(e));
      rest = 3'b111 & ~bus_ack;
      e = top_bit(rest);
      bus_req = rest; cyc_end = 1'b1; tick(); cyc_end = 1'b0;
      check("R4 handover", 32'(bus_ack), 32'(e));
    end

    free_bus();
    bus_req = 3'b001; cyc_end = 1'b1; tick(); cyc_end = 1'b0;
    for (int c = 0; c < 8; c++) begin
      {rel_req, rfsh_req, xacc_req} = 3'b000; tick();
      {rel_req, rfsh_req, xacc_req} = 3'(c); tick();
      er = rel_req && !rfsh_req; ef = rfsh_req; ex = xacc_req && !er;
      check("R7 release", 32'(rel_ack), 32'(er));
      check("R6 refresh", 32'(rfsh_gnt), 32'(ef));
      check("R8 ext access", 32'(xacc_gnt), 32'(ex));
      check("R10 ack", 32'(bus_ack), 1);
    end
    {rel_req, rfsh_req, xacc_req} = 3'b000; tick();
    rel_req = 1'b1; tick();
    rfsh_req = 1'b1; xacc_req = 1'b1; tick(); tick();
    check("R7 held", {rel_ack, rfsh_gnt, xacc_gnt}, 32'h4);
    check("R10 owner", 32'(bus_owner), 1);
    rel_req = 1'b0; tick();
    check("R8 with refresh", {rel_ack, rfsh_gnt, xacc_gnt}, 32'h3);
    rfsh_req = 1'b0; free_bus(); tick();
    check("R8 no master", 32'(xacc_gnt), 0);
    xacc_req = 1'b0;

    foreach (vals[k]) for (int s = 0; s < 2; s++) begin
      rel_req = 1'b0; sleep_mode = 1'b0; tick();
      stop_word = vals[k]; sleep_mode = s[0]; rel_req = 1'b1; tick();
      check("R9 halt decode", 32'(rel_ack),
            (s == 1 && (vals[k] == 16'hFFFF || vals[k] == 16'hEFFF)) ? 0 : 1);
    end
    sleep_mode = 1'b0; stop_word = 16'hEFFF; rel_req = 1'b1; tick();
    check("R9 before halt", 32'(rel_ack), 1);
    sleep_mode = 1'b1; tick();
    check("R9 halt while held", 32'(rel_ack), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule